// File: doc/BRIEF.md
# Buffered PWM Timer Channel

This block is one channel of a compare timer that produces a pulse-width modulated output. An up-counter advances on each enabled tick and returns to zero when it reaches compare register A, so A sets the period. The output goes high when the counter clears and low when the counter reaches compare register B, so B sets the duty. A third compare register, E, can be included through a parameter. It raises a match flag and takes no part in the waveform.

Each compare register has a buffer register behind it: C for A, D for B and F for E. Software writes a new value into a buffer at any time. The value is copied into the active compare register at a moment that a transfer-select register chooses separately for each pair. The copy happens either when that pair's own compare matches or when the counter clears. The counter-clear choice applies only while the channel is in PWM mode. This lets software change period and duty without producing a corrupted cycle. All registers sit on a simple single-cycle bus: the write is synchronous and the read is combinational.

Top module: `pwm_buf_chan`

## Requirements
- R1: After synchronous reset every register reads 0, `pwm_out` is 0 and `match_flags` is 0.
- R2: The counter (address 2) increments by one on each clock in which `cnt_en` is high and the run bit (CTRL address 0, bit 0) is set. In every other cycle it holds, and a bus write to it loads the written value.
- R3: On a tick in which the counter equals compare A (address 3), the counter returns to 0, which gives a period of A+1 ticks. This event is the counter clear.
- R4: `pwm_out` becomes 1 after a counter clear and 0 after a tick in which the counter equals compare B (address 4). When both happen on the same tick, 0 wins.
- R5: The transfer-select register (address 1) holds bit 0 for the A pair, bit 1 for the B pair and bit 2 for the E pair, where 1 selects clear timing. Bits 7 to 3 always read 0. Without the E pair, bit 2 reads 0 and ignores writes.
- R6: With the select bit at 0, compare B takes the value of buffer D (address 7) on a tick in which the counter equals compare B. The copy happens only if the B buffer enable (CTRL bit 3) is set.
- R7: With the select bit at 1 and PWM mode (CTRL bit 1) set, the copy happens at the counter clear and not at the pair's own match. This holds for the A pair with buffer C (address 6, enable CTRL bit 2) and for the B pair.
- R8: With PWM mode clear, a select bit of 1 behaves as 0 and the copy happens on the compare match.
- R9: While a pair's buffer enable is clear, no copy into its compare register takes place.
- R10: If a bus write to a buffer and that pair's transfer event fall in the same cycle, the newly written value is the one copied, and the buffer also holds it.
- R11: A copied value is first compared on the tick after the transfer event.
- R12: The flag register (address 9) and `match_flags` set bit 0, bit 1 or bit 2 on a match of A, B or E. Writing 1 to a bit clears it, and a match in the same cycle wins over the clear.
- R13: Without the E pair, compare E (address 5) and buffer F (address 8) read 0, CTRL bit 4 reads 0, and flag bit 2 never sets.
- R14: With the E pair present, compare E follows buffer F under select bit 2 and enable bit CTRL bit 4, in the same way as the B pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; a tick is cnt_en with the run bit set |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data for bus_addr |
| pwm_out | output | 1 | PWM waveform |
| match_flags | output | 3 | Sticky match flags for A, B, E |

## Verification
The checker assumes that the bus address is always a known value. It also assumes that `CNT_W` is at least 8, so the transfer-select read has reserved upper bits to check. The transfer property for pair B excludes cycles in which the bus writes buffer D, because the forwarded value differs from the stored one in those cycles. The counter-wrap property likewise excludes cycles in which the bus writes the counter. The bench keeps `cnt_en` low during every register write except in the one case that tests a write and a transfer in the same cycle. Each tick therefore follows a fully settled configuration, and expected counts and levels can be computed directly from A, B and the number of ticks.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_XSEL = 4'd1;
    localparam logic [3:0] A_CNT  = 4'd2;
    localparam logic [3:0] A_CMPA = 4'd3;
    localparam logic [3:0] A_CMPB = 4'd4;
    localparam logic [3:0] A_CMPE = 4'd5;
    localparam logic [3:0] A_BUFC = 4'd6;
    localparam logic [3:0] A_BUFD = 4'd7;
    localparam logic [3:0] A_BUFF = 4'd8;
    localparam logic [3:0] A_FLAG = 4'd9;

    localparam int SLOT_A = 0;
    localparam int SLOT_B = 1;
    localparam int SLOT_E = 2;
    localparam int SLOTS_MAX = 3;

    typedef struct packed {
        logic buf_e;
        logic buf_b;
        logic buf_a;
        logic pwm_mode;
        logic run;
    } ctrl_t;

    function automatic logic [3:0] slot_cmp_addr(input int s);
        return A_CMPA + 4'(s);
    endfunction

    function automatic logic [3:0] slot_buf_addr(input int s);
        return A_BUFC + 4'(s);
    endfunction

    function automatic logic [2:0] xsel_mask(input bit has_ef);
        return has_ef ? 3'b111 : 3'b011;
    endfunction

    function automatic logic [4:0] ctrl_mask(input bit has_ef);
        return has_ef ? 5'b11111 : 5'b01111;
    endfunction

endpackage

// File: rtl/pwm_count.sv
module pwm_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wrap,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (wr)   cnt_q <= wdata;
        else if (wrap) cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/pwm_cmp_slot.sv
module pwm_cmp_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic         wr_cmp,
    input  logic         wr_buf,
    input  logic [W-1:0] wdata,
    input  logic         buf_en,
    input  logic         sel_clr,
    input  logic         clr_evt,
    output logic [W-1:0] cmp_q,
    output logic [W-1:0] buf_q,
    output logic         match
);
    logic [W-1:0] buf_next;
    logic         xfer_evt;

    assign match = tick && (cnt == cmp_q);

    always_comb begin
        buf_next = wr_buf ? wdata : buf_q;
        xfer_evt = buf_en && (sel_clr ? clr_evt : match);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            buf_q <= '0;
        end else begin
            buf_q <= buf_next;
            if (xfer_evt)    cmp_q <= buf_next;
            else if (wr_cmp) cmp_q <= wdata;
        end
    end
endmodule

// File: rtl/pwm_buf_chan.sv
module pwm_buf_chan
    import pwm_buf_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter bit HAS_EF = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             pwm_out,
    output logic [2:0]       match_flags
);
    localparam int NSLOT = HAS_EF ? 3 : 2;

    ctrl_t            ctrl_q;
    logic [2:0]       xsel_q;
    logic [2:0]       flag_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             clr_evt;
    logic             wr_cnt;
    logic [2:0]       wr_buf;
    logic [2:0]       wr_cmp;
    logic [2:0]       buf_en;
    logic [2:0]       sel_clr;
    logic [2:0]       match;
    logic [CNT_W-1:0] cmp_q [SLOTS_MAX];
    logic [CNT_W-1:0] buf_q [SLOTS_MAX];

    assign tick    = ctrl_q.run && cnt_en;
    assign clr_evt = match[SLOT_A];
    assign wr_cnt  = bus_we && (bus_addr == A_CNT);
    assign buf_en  = {ctrl_q.buf_e, ctrl_q.buf_b, ctrl_q.buf_a};
    assign sel_clr = xsel_q & {3{ctrl_q.pwm_mode}};

    pwm_count #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wrap  (clr_evt),
        .wr    (wr_cnt),
        .wdata (bus_wdata),
        .cnt_q (cnt_q)
    );

    for (genvar s = 0; s < SLOTS_MAX; s++) begin : g_slot
        assign wr_cmp[s] = bus_we && (bus_addr == slot_cmp_addr(s));
        assign wr_buf[s] = bus_we && (bus_addr == slot_buf_addr(s));
        if (s < NSLOT) begin : g_on
            pwm_cmp_slot #(.W(CNT_W)) u_slot (
                .clk     (clk),
                .rst     (rst),
                .tick    (tick),
                .cnt     (cnt_q),
                .wr_cmp  (wr_cmp[s]),
                .wr_buf  (wr_buf[s]),
                .wdata   (bus_wdata),
                .buf_en  (buf_en[s]),
                .sel_clr (sel_clr[s]),
                .clr_evt (clr_evt),
                .cmp_q   (cmp_q[s]),
                .buf_q   (buf_q[s]),
                .match   (match[s])
            );
        end else begin : g_off
            assign cmp_q[s] = '0;
            assign buf_q[s] = '0;
            assign match[s] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            xsel_q  <= '0;
            flag_q  <= '0;
            pwm_out <= 1'b0;
        end else begin
            if (bus_we && bus_addr == A_CTRL)
                ctrl_q <= ctrl_t'(bus_wdata[4:0] & ctrl_mask(HAS_EF));
            if (bus_we && bus_addr == A_XSEL)
                xsel_q <= bus_wdata[2:0] & xsel_mask(HAS_EF);
            if (bus_we && bus_addr == A_FLAG)
                flag_q <= (flag_q & ~bus_wdata[2:0]) | match;
            else
                flag_q <= flag_q | match;
            if (match[SLOT_B])  pwm_out <= 1'b0;
            else if (clr_evt)   pwm_out <= 1'b1;
        end
    end

    assign match_flags = flag_q;

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = CNT_W'(ctrl_q);
            A_XSEL:  bus_rdata = CNT_W'(xsel_q);
            A_CNT:   bus_rdata = cnt_q;
            A_CMPA:  bus_rdata = cmp_q[SLOT_A];
            A_CMPB:  bus_rdata = cmp_q[SLOT_B];
            A_CMPE:  bus_rdata = cmp_q[SLOT_E];
            A_BUFC:  bus_rdata = buf_q[SLOT_A];
            A_BUFD:  bus_rdata = buf_q[SLOT_B];
            A_BUFF:  bus_rdata = buf_q[SLOT_E];
            A_FLAG:  bus_rdata = CNT_W'(flag_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwm_buf_chan_chk.sv
module pwm_buf_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_a,
    input logic [CNT_W-1:0] cmp_b,
    input logic [CNT_W-1:0] buf_d,
    input logic             buf_b_en,
    input logic             sel_b_clr,
    input logic             wr_cnt,
    input logic             wr_bufd,
    input logic             pwm_out,
    input logic             flag_b,
    input logic [3:0]       bus_addr,
    input logic [CNT_W-1:0] bus_rdata
);
    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == cmp_a && !wr_cnt) |=> (cnt == '0));

    // R4
    pwm_low_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == cmp_b) |=> !pwm_out);

    // R4
    pwm_high_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == cmp_a && cnt != cmp_b) |=> pwm_out);

    // R6
    xfer_match_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == cmp_b && buf_b_en && !sel_b_clr && !wr_bufd)
        |=> (cmp_b == $past(buf_d)));

    // R12
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == cmp_b) |=> flag_b);

    // R5
    xsel_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 4'd1) |-> (bus_rdata[CNT_W-1:3] == '0));
endmodule

bind pwm_buf_chan pwm_buf_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt       (cnt_q),
    .cmp_a     (cmp_q[0]),
    .cmp_b     (cmp_q[1]),
    .buf_d     (buf_q[1]),
    .buf_b_en  (buf_en[1]),
    .sel_b_clr (sel_clr[1]),
    .wr_cnt    (wr_cnt),
    .wr_bufd   (wr_buf[1]),
    .pwm_out   (pwm_out),
    .flag_b    (flag_q[1]),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/pwm_buf_chan_bench.sv
module pwm_buf_chan_bench;
    localparam int W = 16;
    localparam logic [3:0] CTRL = 0, XSEL = 1, CNT = 2, CMPA = 3, CMPB = 4,
                           CMPE = 5, BUFC = 6, BUFD = 7, BUFF = 8, FLAG = 9;

    logic         clk = 0;
    logic         rst = 1;
    logic         cnt_en = 0;
    logic         bus_we = 0;
    logic [3:0]   bus_addr = 0;
    logic [W-1:0] bus_wdata = 0;
    logic [W-1:0] rdata, rdata2;
    logic         pwm, pwm2;
    logic [2:0]   flags, flags2;
    int           checks = 0;
    int           fails = 0;

    always #2 clk = ~clk;

    pwm_buf_chan #(.CNT_W(W), .HAS_EF(1'b1)) u_pwm_buf_chan (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .pwm_out(pwm), .match_flags(flags));

    pwm_buf_chan #(.CNT_W(W), .HAS_EF(1'b0)) u_noef (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
        .pwm_out(pwm2), .match_flags(flags2));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [3:0] a, input logic [W-1:0] d, input logic en);
        bus_we = we; bus_addr = a; bus_wdata = d; cnt_en = en;
        @(posedge clk); #1;
        bus_we = 0; cnt_en = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, '0, 1'b1);
    endtask

    task automatic rd(input logic [3:0] a, output logic [W-1:0] v, output logic [W-1:0] v2);
        bus_addr = a; #1; v = rdata; v2 = rdata2;
    endtask

    task automatic setup(input logic [4:0] c, input logic [2:0] x,
                         input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] n);
        wr(CTRL, 0); wr(XSEL, W'(x)); wr(CMPA, a); wr(CMPB, b);
        wr(CNT, n); wr(FLAG, 7); wr(CTRL, W'(c));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] v, v2;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v, v2);
            chk("R1 reg", {16'(a), v}, {16'(a), 16'h0});
        end
        chk("R1 pwm", pwm, 0);
        chk("R1 flags", flags, 0);

        // R5 transfer-select reserved bits, R13 absent E pair
        wr(XSEL, 16'hFFFF); rd(XSEL, v, v2);
        chk("R5 xsel ef", v, 7);
        chk("R5 xsel noef", v2, 3);
        wr(CTRL, 16'h1E); rd(CTRL, v, v2);
        chk("R13 ctrl noef", v2, 16'h0E);
        wr(CMPE, 5); wr(BUFF, 6); rd(CMPE, v, v2);
        chk("R13 cmpe noef", v2, 0);
        chk("R14 cmpe ef", v, 5);
        rd(BUFF, v, v2);
        chk("R13 buff noef", v2, 0);

        // R2 hold without run / without cnt_en
        setup(5'h00, 0, 9, 3, 4);
        tick(3); rd(CNT, v, v2);
        chk("R2 hold run off", v, 4);
        wr(CTRL, 1); wr(BUFD, 1); rd(CNT, v, v2);
        chk("R2 hold en off", v, 4);
        tick(2); rd(CNT, v, v2);
        chk("R2 count", v, 6);

        // R2 R3 R4 sweep over period and duty
        for (int a = 1; a <= 5; a++) begin
            for (int b = 0; b < a; b++) begin
                setup(5'h01, 0, W'(a), W'(b), 0);
                for (int k = 1; k <= 3 * (a + 1); k++) begin
                    tick(1); rd(CNT, v, v2);
                    chk("R3 cnt", v, 32'(k % (a + 1)));
                    if (k >= a + 1) chk("R4 pwm", pwm, 32'((k % (a + 1)) <= b));
                end
            end
        end
        // R4 B equal to A: low wins
        setup(5'h01, 0, 3, 3, 0);
        for (int k = 1; k <= 8; k++) begin
            tick(1);
            if (k >= 4) chk("R4 tie", pwm, 0);
        end

        // R6 match-timed transfer
        setup(5'h0B, 0, 9, 3, 1); wr(BUFD, 6);
        tick(2); rd(CMPB, v, v2);
        chk("R6 before match", v, 3);
        tick(1); rd(CMPB, v, v2);
        chk("R6 after match", v, 6);

        // R7 clear-timed transfer on B
        setup(5'h0B, 3'b010, 9, 3, 1); wr(BUFD, 6);
        tick(3); rd(CMPB, v, v2);
        chk("R7 not at match", v, 3);
        wr(CNT, 9); tick(1); rd(CMPB, v, v2);
        chk("R7 at clear", v, 6);

        // R8 select ignored outside PWM mode
        setup(5'h09, 3'b010, 9, 3, 1); wr(BUFD, 6);
        tick(3); rd(CMPB, v, v2);
        chk("R8 match timing", v, 6);

        // R9 buffer disabled
        setup(5'h03, 0, 9, 3, 1); wr(BUFD, 6);
        tick(3); rd(CMPB, v, v2);
        chk("R9 no xfer match", v, 3);
        wr(CNT, 9); tick(1); rd(CMPB, v, v2);
        chk("R9 no xfer clear", v, 3);

        // R10 write and transfer in the same cycle
        setup(5'h0B, 0, 9, 3, 3); wr(BUFD, 6);
        cyc(1'b1, BUFD, 7, 1'b1);
        rd(CMPB, v, v2);
        chk("R10 cmpb", v, 7);
        rd(BUFD, v, v2);
        chk("R10 bufd", v, 7);

        // R11 copied value compared on the next tick; R12 flags
        setup(5'h0B, 0, 9, 3, 3); wr(BUFD, 4);
        tick(1); rd(FLAG, v, v2);
        chk("R12 flag b set", v, 2);
        chk("R12 flag port", flags, 2);
        wr(FLAG, 2); rd(FLAG, v, v2);
        chk("R12 flag cleared", v, 0);
        tick(1); rd(FLAG, v, v2);
        chk("R11 new value match", v, 2);

        // R7 on the A pair: period reload at clear
        setup(5'h07, 3'b001, 9, 3, 8); wr(BUFC, 4);
        tick(1); rd(CMPA, v, v2);
        chk("R7 cmpa hold", v, 9);
        tick(1); rd(CMPA, v, v2);
        chk("R7 cmpa load", v, 4);
        tick(4); rd(CNT, v, v2);
        chk("R7 new period top", v, 4);
        tick(1); rd(CNT, v, v2);
        chk("R7 new period wrap", v, 0);

        // R14 E pair, clear timing then match timing; R13 flag E absent
        setup(5'h13, 3'b100, 9, 8, 1); wr(CMPE, 2); wr(BUFF, 5);
        tick(2); rd(CMPE, v, v2);
        chk("R14 cmpe at match w/ clear sel", v, 2);
        rd(FLAG, v, v2);
        chk("R12 flag e", v & 4, 4);
        chk("R13 noef flag e", v2 & 4, 0);
        wr(CNT, 9); tick(1); rd(CMPE, v, v2);
        chk("R14 cmpe at clear", v, 5);
        setup(5'h13, 0, 9, 8, 2); wr(CMPE, 2); wr(BUFF, 7);
        tick(1); rd(CMPE, v, v2);
        chk("R14 cmpe at match", v, 7);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule